// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor read a serial NOR flash as if the flash were ordinary memory. A read request on a simple request/ready bus takes over the flash chip select. The engine then runs one complete flash read command and returns the fetched bytes on the bus read response. The command has an optional opcode, a 3- or 4-byte address taken from the bus offset, a programmable number of dummy clocks, and a data phase on one, two or four lines.

All framing comes from a transfer-control word held elsewhere in the controller. The engine derives the read opcode from the framing bits instead of storing it. A map-enable flag, set at reset, decides whether bus reads are served. While it is cleared the controller belongs to register-driven transfers. A register-driven transfer that is still busy holds off a new bus read until it ends. The serial clock uses mode 0: it idles low, outputs change after the falling edge and inputs are sampled on the rising edge.

Top module: `flash_map_reader`

## Requirements
- R1: The map-enable flag is 1 after reset. Writing 0 makes bus reads produce no chip-select activity and no ready. Writing 1 restores service.
- R2: The opcode is picked from control bits 5:4 (data width), bit 3 (fast) and bit 21 (4-byte variant). Quad (bit 5 set) sends 0x6B, or 0x6C with bit 21. Dual (only bit 4 set) sends 0x3B or 0x3C. Single line with fast sends 0x0B or 0x0C. Otherwise 0x03 or 0x13 is sent.
- R3: Control bit 11 set sends the 8-bit opcode before the address. When bit 11 is clear, the first serial bits are the address.
- R4: The address is 4 bytes when bit 20 is set or bits 10:8 equal 4, and 3 bytes otherwise. It is sent MSB first on io_out[0] and equals the bus offset (low 24 bits when 3 bytes are sent).
- R5: Control bits 19:16 give the number of dummy SCK cycles between address and data, from 0 to 15.
- R6: Opcode and address always use one line. Data uses io_in[1] in single mode, io_in[1:0] in dual mode and io_in[3:0] in quad mode. Each byte arrives MSB first, with the highest line carrying the higher bit.
- R7: rd_data carries BUS_BYTES consecutive flash bytes starting at the requested address, with the byte at the requested address in bits 7:0.
- R8: Each bus read drives chip select low exactly once. Chip select is high again when rd_ready rises. rd_ready is a single-cycle pulse.
- R9: While reg_busy is high no new command starts. A pending read starts after reg_busy falls.
- R10: SCK is low whenever chip select is high. io_oe is nonzero only during the opcode and address phases, with io_oe = 4'b0001.
- R11: The SCK rising edges in one command total opcode bits + address bits + dummy cycles + BUS_BYTES*8/width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_en_we | input | 1 | Write strobe for the map-enable flag |
| map_en_d | input | 1 | New map-enable value |
| xfer_cfg | input | 22 | Transfer-control framing word |
| reg_busy | input | 1 | Register-driven transfer in progress |
| rd_req | input | 1 | Bus read request, held until rd_ready |
| rd_addr | input | AW | Byte offset into the flash window |
| rd_ready | output | 1 | One-cycle read completion pulse |
| rd_data | output | 8*BUS_BYTES | Read data, lowest address in bits 7:0 |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Flash chip select, active low |
| io_out | output | 4 | Serial data out |
| io_oe | output | 4 | Output enables for io_out |
| io_in | input | 4 | Serial data in |

## Verification
The hardest case to reach is a bus read that arrives while a register-driven transfer is busy. The request has to sit stalled for many cycles with no chip-select edge, and then start cleanly when the busy flag drops. The bench raises reg_busy before it presents the request and holds it there while watching cs_n and rd_ready. A behavioural flash model drives data on the falling SCK edges, so the late-started command is also checked for correct data. Random framing words, covering every width, dummy count and address-size encoding, are combined with directed runs through all eight opcodes.

// File: rtl/flash_map_pkg.sv
package flash_map_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_DUMMY,
    ST_DATA,
    ST_DONE
  } seq_st_t;

  // framing bit positions inside the transfer-control word
  localparam int BIT_FAST   = 3;
  localparam int BIT_W2     = 4;
  localparam int BIT_W4     = 5;
  localparam int BIT_CMD    = 11;
  localparam int BIT_A4EN   = 20;
  localparam int BIT_A4OP   = 21;
  localparam int CFG_W      = 22;

  // wsel: 0 single, 1 dual, 2 quad
  function automatic logic [7:0] pick_opcode(input logic [1:0] wsel,
                                             input logic fast,
                                             input logic op4b);
    logic [7:0] op;
    case (wsel)
      2'd2:    op = op4b ? 8'h6C : 8'h6B;
      2'd1:    op = op4b ? 8'h3C : 8'h3B;
      default: op = fast ? (op4b ? 8'h0C : 8'h0B) : (op4b ? 8'h13 : 8'h03);
    endcase
    return op;
  endfunction

endpackage

// File: rtl/fm_frame_decode.sv
module fm_frame_decode
  import flash_map_pkg::*;
#(
  parameter int BUS_BYTES = 4,
  parameter int CW        = 6
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [7:0]       opcode,
  output logic             send_cmd,
  output logic             addr4,
  output logic [CW-1:0]    send_cyc,
  output logic [3:0]       dmy_cyc,
  output logic [CW-1:0]    data_cyc,
  output logic [1:0]       wsel
);
  logic cfg_unused;
  assign cfg_unused = ^{cfg[15:12], cfg[7:6], cfg[2:0]};

  always_comb begin
    wsel     = cfg[BIT_W4] ? 2'd2 : (cfg[BIT_W2] ? 2'd1 : 2'd0);
    send_cmd = cfg[BIT_CMD];
    addr4    = cfg[BIT_A4EN] | (cfg[10:8] == 3'd4);
    opcode   = pick_opcode(wsel, cfg[BIT_FAST], cfg[BIT_A4OP]);
    send_cyc = CW'(send_cmd ? 8 : 0) + CW'(addr4 ? 32 : 24);
    dmy_cyc  = cfg[19:16];
    data_cyc = CW'(BUS_BYTES * 8) >> wsel;
  end
endmodule

// File: rtl/fm_sck_timer.sv
module fm_sck_timer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] LAST = HW'(HALF - 1);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/fm_seq.sv
module fm_seq
  import flash_map_pkg::*;
#(
  parameter int BUS_BYTES = 4,
  parameter int CW        = 6,
  parameter int AW        = 26
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   tick,
  input  logic [AW-1:0]          addr,
  input  logic [7:0]             opcode,
  input  logic                   send_cmd,
  input  logic                   addr4,
  input  logic [CW-1:0]          send_cyc,
  input  logic [3:0]             dmy_cyc,
  input  logic [CW-1:0]          data_cyc,
  input  logic [1:0]             wsel,
  input  logic [3:0]             io_in,
  output logic                   idle,
  output logic                   run,
  output logic                   done,
  output logic                   sck,
  output logic                   cs_n,
  output logic [3:0]             io_out,
  output logic [3:0]             io_oe,
  output logic [BUS_BYTES*8-1:0] rx
);
  localparam int RW = BUS_BYTES * 8;

  seq_st_t        st;
  logic [39:0]    tx;
  logic [CW-1:0]  cnt;
  logic [3:0]     dmy_q;
  logic [CW-1:0]  dat_q;
  logic [1:0]     w_q;
  logic [31:0]    addr32;
  logic [31:0]    abits;
  logic [39:0]    tx_load;
  logic [RW-1:0]  rx_next;

  always_comb begin
    addr32  = 32'(addr);
    abits   = addr4 ? addr32 : {addr32[23:0], 8'h00};
    tx_load = send_cmd ? {opcode, abits} : {abits, 8'h00};
    case (w_q)
      2'd0:    rx_next = {rx[RW-2:0], io_in[1]};
      2'd1:    rx_next = {rx[RW-3:0], io_in[1:0]};
      default: rx_next = {rx[RW-5:0], io_in[3:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      sck   <= 1'b0;
      cs_n  <= 1'b1;
      tx    <= '0;
      cnt   <= '0;
      dmy_q <= '0;
      dat_q <= '0;
      w_q   <= '0;
      rx    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            cs_n  <= 1'b0;
            sck   <= 1'b0;
            tx    <= tx_load;
            cnt   <= send_cyc;
            dmy_q <= dmy_cyc;
            dat_q <= data_cyc;
            w_q   <= wsel;
            rx    <= '0;
            st    <= ST_SEND;
          end
        end
        ST_SEND, ST_DUMMY, ST_DATA: begin
          if (tick) begin
            if (!sck) begin
              sck <= 1'b1;
              if (st == ST_DATA) rx <= rx_next;
            end else begin
              sck <= 1'b0;
              if (st == ST_SEND) tx <= {tx[38:0], 1'b0};
              if (cnt == CW'(1)) begin
                case (st)
                  ST_SEND: begin
                    if (dmy_q != 4'd0) begin
                      st  <= ST_DUMMY;
                      cnt <= CW'(dmy_q);
                    end else begin
                      st  <= ST_DATA;
                      cnt <= dat_q;
                    end
                  end
                  ST_DUMMY: begin
                    st  <= ST_DATA;
                    cnt <= dat_q;
                  end
                  default: begin
                    cs_n <= 1'b1;
                    st   <= ST_DONE;
                  end
                endcase
              end else begin
                cnt <= cnt - 1'b1;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle   = (st == ST_IDLE);
  assign done   = (st == ST_DONE);
  assign run    = (st == ST_SEND) || (st == ST_DUMMY) || (st == ST_DATA);
  assign io_out = {3'b000, tx[39]};
  assign io_oe  = (st == ST_SEND) ? 4'b0001 : 4'b0000;
endmodule

// File: rtl/flash_map_reader.sv
module flash_map_reader
  import flash_map_pkg::*;
#(
  parameter int AW        = 26,
  parameter int BUS_BYTES = 4,
  parameter int SCK_HALF  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   map_en_we,
  input  logic                   map_en_d,
  input  logic [21:0]            xfer_cfg,
  input  logic                   reg_busy,
  input  logic                   rd_req,
  input  logic [AW-1:0]          rd_addr,
  output logic                   rd_ready,
  output logic [8*BUS_BYTES-1:0] rd_data,
  output logic                   sck,
  output logic                   cs_n,
  output logic [3:0]             io_out,
  output logic [3:0]             io_oe,
  input  logic [3:0]             io_in
);
  localparam int MAXC = (BUS_BYTES * 8 > 40) ? BUS_BYTES * 8 : 40;
  localparam int CW   = $clog2(MAXC + 1);

  logic                   map_en_q;
  logic [7:0]             opcode;
  logic                   send_cmd, addr4;
  logic [CW-1:0]          send_cyc, data_cyc;
  logic [3:0]             dmy_cyc;
  logic [1:0]             wsel;
  logic                   idle, run, done, tick, start;
  logic [8*BUS_BYTES-1:0] rx;
  logic [8*BUS_BYTES-1:0] rx_swap;

  always_ff @(posedge clk) begin
    if (rst)            map_en_q <= 1'b1;
    else if (map_en_we) map_en_q <= map_en_d;
  end

  assign start = rd_req && map_en_q && !reg_busy && idle && !rd_ready;

  fm_frame_decode #(.BUS_BYTES(BUS_BYTES), .CW(CW)) u_dec (
    .cfg(xfer_cfg), .opcode(opcode), .send_cmd(send_cmd), .addr4(addr4),
    .send_cyc(send_cyc), .dmy_cyc(dmy_cyc), .data_cyc(data_cyc), .wsel(wsel)
  );

  fm_sck_timer #(.HALF(SCK_HALF)) u_tmr (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  fm_seq #(.BUS_BYTES(BUS_BYTES), .CW(CW), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .tick(tick), .addr(rd_addr),
    .opcode(opcode), .send_cmd(send_cmd), .addr4(addr4),
    .send_cyc(send_cyc), .dmy_cyc(dmy_cyc), .data_cyc(data_cyc),
    .wsel(wsel), .io_in(io_in), .idle(idle), .run(run), .done(done),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .rx(rx)
  );

  // first serial byte is the lowest address: place it in the low lane
  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    assign rx_swap[8*i +: 8] = rx[8*(BUS_BYTES-1-i) +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ready <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_ready <= done;
      if (done) rd_data <= rx_swap;
    end
  end
endmodule

// File: rtl/fm_checker.sv
module fm_checker (
  input logic       clk,
  input logic       rst,
  input logic       rd_ready,
  input logic       cs_n,
  input logic       sck,
  input logic [3:0] io_oe,
  input logic       reg_busy,
  input logic       map_en_q
);
  p_ready_cs_high_r8: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> cs_n);

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rd_ready |=> !rd_ready);

  p_start_enabled_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(map_en_q));

  p_start_not_busy_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !$past(reg_busy));

  p_sck_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);

  p_oe_framed_r10: assert property (@(posedge clk) disable iff (rst)
    (io_oe != 4'b0000) |-> (!cs_n && io_oe == 4'b0001));
endmodule

bind flash_map_reader fm_checker u_chk (
  .clk(clk), .rst(rst), .rd_ready(rd_ready), .cs_n(cs_n), .sck(sck),
  .io_oe(io_oe), .reg_busy(reg_busy), .map_en_q(map_en_q)
);

// File: tb/sim_flash_map_reader.sv
module sim_flash_map_reader;
  localparam int AW = 26;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          map_en_we = 1'b0, map_en_d = 1'b0;
  logic [21:0]   xfer_cfg = '0;
  logic          reg_busy = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_ready;
  logic [8*NB-1:0] rd_data;
  logic          sck, cs_n;
  logic [3:0]    io_out, io_oe;
  logic [3:0]    io_in = '0;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  flash_map_reader #(.AW(AW), .BUS_BYTES(NB), .SCK_HALF(2)) u0 (
    .clk(clk), .rst(rst), .map_en_we(map_en_we), .map_en_d(map_en_d),
    .xfer_cfg(xfer_cfg), .reg_busy(reg_busy), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data), .sck(sck),
    .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  // ---------------- flash model ----------------
  int          rises = 0, csfalls = 0;
  longint      cap = 0;
  int          m_nsend = 32, m_base = 32, m_w = 1;
  logic [31:0] m_faddr = '0;

  function automatic logic [7:0] fbyte(input logic [31:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ {a[22:16], 1'b1} ^ 8'hA5;
  endfunction

  always @(negedge cs_n) begin
    rises = 0;
    cap = 0;
    csfalls++;
  end

  always @(posedge sck) if (!cs_n) begin
    if (rises < m_nsend) cap = {cap[62:0], io_out[0]};
    rises++;
  end

  always @(negedge sck) if (!cs_n && rises >= m_base) begin
    int bp, off, v;
    logic [7:0] by;
    bp  = (rises - m_base) * m_w;
    off = bp % 8;
    by  = fbyte(m_faddr + 32'(bp / 8));
    v   = (int'(by) >> (8 - m_w - off)) & ((1 << m_w) - 1);
    if (m_w == 1)      io_in = {2'b00, v[0], 1'b0};
    else if (m_w == 2) io_in = {2'b00, v[1:0]};
    else               io_in = v[3:0];
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_op(input logic [21:0] c);
    if (c[5])      return c[21] ? 8'h6C : 8'h6B;
    else if (c[4]) return c[21] ? 8'h3C : 8'h3B;
    else if (c[3]) return c[21] ? 8'h0C : 8'h0B;
    else           return c[21] ? 8'h13 : 8'h03;
  endfunction

  // a4mode: 0 -> bits10:8=3, 1 -> bits10:8=4, 2 -> bit20 with bits10:8=3
  function automatic logic [21:0] mk_cfg(input bit cmd, input int a4mode, input bit fast,
                                         input logic [1:0] w, input logic [3:0] dmy, input bit op4);
    logic [21:0] c = '0;
    c[11]    = cmd;
    c[10:8]  = (a4mode == 1) ? 3'd4 : 3'd3;
    c[20]    = (a4mode == 2);
    c[3]     = fast;
    c[5:4]   = w;
    c[19:16] = dmy;
    c[21]    = op4;
    return c;
  endfunction

  task automatic do_read(input logic [AW-1:0] a, input logic [21:0] c, input int busy_cyc);
    int nab, csf0, tot, wdg;
    bit seen, cs_hi;
    logic [8*NB-1:0] got, expd;
    logic [31:0] fa;
    nab = (c[20] || c[10:8] == 3'd4) ? 4 : 3;
    fa  = (nab == 4) ? 32'(a) : {8'h00, 24'(a)};
    @(negedge clk);
    xfer_cfg = c;
    m_w      = c[5] ? 4 : (c[4] ? 2 : 1);
    m_nsend  = (c[11] ? 8 : 0) + nab * 8;
    m_base   = m_nsend + int'(c[19:16]);
    m_faddr  = fa;
    csf0     = csfalls;
    rd_addr  = a;
    rd_req   = 1'b1;
    if (busy_cyc > 0) begin
      reg_busy = 1'b1;
      seen = 0;
      for (int k = 0; k < busy_cyc; k++) begin
        @(negedge clk);
        if (rd_ready) seen = 1;
      end
      chk(!seen && csfalls == csf0, "R9 stall while busy", csfalls - csf0, 0);
      reg_busy = 1'b0;
    end
    wdg = 0;
    seen = 0;
    while (!seen && wdg < 5000) begin
      @(negedge clk);
      wdg++;
      if (rd_ready) begin
        seen  = 1;
        got   = rd_data;
        cs_hi = cs_n;
      end
    end
    rd_req = 1'b0;
    chk(seen, "R8 ready returned", seen, 1);
    if (!seen) return;
    chk(cs_hi, "R8 cs high at ready", cs_hi, 1);
    chk(csfalls - csf0 == 1, "R8 one select per read", csfalls - csf0, 1);
    tot = m_base + NB * 8 / m_w;
    chk(rises == tot, "R11 R5 sck cycle total", rises, tot);
    if (c[11])
      chk(((cap >> (nab * 8)) & 8'hFF) == exp_op(c), "R2 R3 opcode",
          (cap >> (nab * 8)) & 8'hFF, exp_op(c));
    else
      chk(m_nsend == nab * 8, "R3 no opcode", m_nsend, nab * 8);
    chk((cap & ((64'd1 << (nab * 8)) - 1)) == longint'(fa), "R4 address",
        cap & ((64'd1 << (nab * 8)) - 1), fa);
    for (int i = 0; i < NB; i++) expd[8*i +: 8] = fbyte(fa + 32'(i));
    chk(got == expd, "R7 R6 data", got, expd);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int r;
    bit seen;
    int csf0;
    r = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n && !sck && !rd_ready && io_oe == 4'b0, "R10 reset idle", {cs_n, sck, rd_ready}, 3'b100);

    // R1: enabled from reset, no write needed
    do_read(26'h0001_234, mk_cfg(1, 0, 0, 2'd0, 4'd0, 0), 0);

    // R2: all eight opcodes
    for (int op4 = 0; op4 < 2; op4++) begin
      do_read(26'h0000_040, mk_cfg(1, 0, 1, 2'd0, 4'd8, op4[0]), 0);
      do_read(26'h0000_081, mk_cfg(1, 0, 0, 2'd1, 4'd8, op4[0]), 0);
      do_read(26'h0000_0C2, mk_cfg(1, 0, 0, 2'd2, 4'd6, op4[0]), 0);
      do_read(26'h0000_103, mk_cfg(1, 0, 0, 2'd0, 4'd0, op4[0]), 0);
    end
    // R3 no opcode, R4 address size encodings, R5 dummy extremes, R6 width 3
    do_read(26'h0ABC_DEF, mk_cfg(0, 0, 0, 2'd0, 4'd0, 0), 0);
    do_read(26'h3ABC_DEF, mk_cfg(1, 1, 0, 2'd0, 4'd0, 1), 0);
    do_read(26'h2FED_CBA, mk_cfg(1, 2, 0, 2'd2, 4'd15, 1), 0);
    do_read(26'h1000_00F, mk_cfg(1, 0, 0, 2'd3, 4'd15, 0), 0);

    // R1: disabled reads are ignored
    @(negedge clk); map_en_we = 1'b1; map_en_d = 1'b0;
    @(negedge clk); map_en_we = 1'b0;
    csf0 = csfalls;
    rd_addr = 26'h0000_100;
    rd_req = 1'b1;
    seen = 0;
    repeat (120) begin
      @(negedge clk);
      if (rd_ready) seen = 1;
    end
    rd_req = 1'b0;
    chk(!seen && csfalls == csf0, "R1 disabled no activity", csfalls - csf0, 0);
    @(negedge clk); map_en_we = 1'b1; map_en_d = 1'b1;
    @(negedge clk); map_en_we = 1'b0;
    do_read(26'h0000_100, mk_cfg(1, 0, 0, 2'd1, 4'd4, 0), 0);

    // R9: wait behind a register-driven transfer
    do_read(26'h0055_AA0, mk_cfg(1, 1, 1, 2'd0, 4'd8, 1), 60);

    // random framing
    for (int n = 0; n < 40; n++) begin
      logic [21:0] c;
      c = mk_cfg(($urandom % 4) != 0, $urandom % 3, $urandom % 2,
                 2'($urandom % 4), 4'($urandom % 16), $urandom % 2);
      do_read(AW'($urandom), c, (n % 7 == 3) ? 30 : 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule